// File: doc/BRIEF.md
# Predicated Integer Execution Unit

This block is the integer execute stage of a 32-bit RISC pipeline. Each accepted instruction brings two operands, a 4-bit operation select, a 4-bit condition code and a request to update the status flags. The unit holds a four-bit N/Z/C/V flag register. It evaluates the condition against those flags before it allows the operation to have any effect.

When the condition holds, the unit computes one of sixteen arithmetic, logical, move or compare operations. It returns the result with a write-enable one clock later and, when asked to, loads new flags. When the condition does not hold, the unit still returns a valid beat, but nothing is written and the flags keep their values. An instruction that follows directly on the next clock sees the flags left by the one before it. Register read and write, shifting, multiplication and decode are done outside this block.

Top module: `pred_exec_unit`

## Requirements
- R1: While `rst_n` is low, `out_valid` and `out_we` are 0 and `out_flags` is 4'b0000.
- R2: Each clock edge with `in_valid`=1 produces `out_valid`=1 on the following cycle, and an edge with `in_valid`=0 produces `out_valid`=0 with the flags held. `out_we` is never 1 without `out_valid`.
- R3: Condition codes (`in_cond`) are 0000 Z=1, 0001 Z=0, 0010 C=1, 0011 C=0, 0100 N=1, 0101 N=0, 0110 V=1, 0111 V=0, and 1110 always. Every other code never passes.
- R4: When the condition fails, the beat is still returned with `out_valid`=1, but `out_we`=0 and `out_flags` are unchanged.
- R5: Arithmetic operations (`in_op`) are 0100 A+B, 0101 A+B+C, 0010 A−B, 0110 A−B−(1−C), 0011 B−A and 0111 B−A−(1−C), each giving a 32-bit wrapped result.
- R6: For the subtracting forms, C is set when no borrow occurs: C=1 when the minuend is greater than or equal to the subtrahend plus the borrow, compared unsigned. For the adding forms, C is the carry out of bit 31.
- R7: V is set by arithmetic operations when the result overflows as a signed 32-bit value.
- R8: Logical and move operations are 0000 A AND B, 0001 A XOR B, 1100 A OR B, 1110 A AND NOT B, 1101 B, and 1111 NOT B.
- R9: Logical, move and test operations update only N (result bit 31) and Z (result equal to zero). C and V keep their previous values.
- R10: Compare operations, 1000 test (AND), 1001 test-equivalence (XOR), 1010 compare (A−B) and 1011 compare-negative (A+B), never assert `out_we`. When their condition passes, they always update the flags, whatever the value of `in_setf`.
- R11: A passing non-compare operation with `in_setf`=0 leaves the flags unchanged.
- R12: `out_flags` is {N,Z,C,V} with N at bit 3. Flags loaded by one instruction are used for the condition of an instruction issued on the very next clock.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Instruction present this cycle |
| in_op | input | 4 | Operation select |
| in_cond | input | 4 | Condition code |
| in_setf | input | 1 | Request flag update |
| in_a | input | 32 | First operand |
| in_b | input | 32 | Second operand |
| out_valid | output | 1 | Registered beat for the accepted instruction |
| out_we | output | 1 | Result is to be written |
| out_result | output | 32 | Operation result |
| out_flags | output | 4 | Held flags {N,Z,C,V} |

## Verification
The bench targets the carry convention of the subtracting forms, and in particular the reverse and borrow-in variants. A design that swaps the operands wrongly, or that inverts the sense of the borrow, shows a wrong C on values such as 3−5 and on equal operands. It sweeps all sixteen condition codes under several flag states. This catches an unused code that executes, or a test that reads the wrong flag. It also checks that logical operations keep C and V and that compare operations set flags without `in_setf`. A design that clears C and V, or that depends on `in_setf` for compares, shows stale or lost flags. A compare followed at once by a conditional add exposes a flag register that is a cycle late.

// File: rtl/pxu_pkg.sv
package pxu_pkg;
  // operation select encodings
  localparam logic [3:0] OP_AND = 4'd0;
  localparam logic [3:0] OP_EOR = 4'd1;
  localparam logic [3:0] OP_SUB = 4'd2;
  localparam logic [3:0] OP_RSB = 4'd3;
  localparam logic [3:0] OP_ADD = 4'd4;
  localparam logic [3:0] OP_ADC = 4'd5;
  localparam logic [3:0] OP_SBC = 4'd6;
  localparam logic [3:0] OP_RSC = 4'd7;
  localparam logic [3:0] OP_TST = 4'd8;
  localparam logic [3:0] OP_TEQ = 4'd9;
  localparam logic [3:0] OP_CMP = 4'd10;
  localparam logic [3:0] OP_CMN = 4'd11;
  localparam logic [3:0] OP_ORR = 4'd12;
  localparam logic [3:0] OP_MOV = 4'd13;
  localparam logic [3:0] OP_BIC = 4'd14;
  localparam logic [3:0] OP_MVN = 4'd15;

  // condition encodings
  localparam logic [3:0] CC_EQ = 4'd0;
  localparam logic [3:0] CC_NE = 4'd1;
  localparam logic [3:0] CC_CS = 4'd2;
  localparam logic [3:0] CC_CC = 4'd3;
  localparam logic [3:0] CC_MI = 4'd4;
  localparam logic [3:0] CC_PL = 4'd5;
  localparam logic [3:0] CC_VS = 4'd6;
  localparam logic [3:0] CC_VC = 4'd7;
  localparam logic [3:0] CC_AL = 4'd14;

  // flag bit positions inside the 4-bit flag word
  localparam int FL_N = 3;
  localparam int FL_Z = 2;
  localparam int FL_C = 1;
  localparam int FL_V = 0;

  function automatic logic is_compare(input logic [3:0] op);
    return op[3:2] == 2'b10;
  endfunction

  function automatic logic is_arith(input logic [3:0] op);
    return (op inside {OP_SUB, OP_RSB, OP_ADD, OP_ADC, OP_SBC, OP_RSC, OP_CMP, OP_CMN});
  endfunction
endpackage

// File: rtl/pxu_cond_check.sv
module pxu_cond_check
  import pxu_pkg::*;
(
  input  logic [3:0] cond,
  input  logic [3:0] flags,
  output logic       pass
);
  always_comb begin
    unique case (cond)
      CC_EQ:   pass = flags[FL_Z];
      CC_NE:   pass = ~flags[FL_Z];
      CC_CS:   pass = flags[FL_C];
      CC_CC:   pass = ~flags[FL_C];
      CC_MI:   pass = flags[FL_N];
      CC_PL:   pass = ~flags[FL_N];
      CC_VS:   pass = flags[FL_V];
      CC_VC:   pass = ~flags[FL_V];
      CC_AL:   pass = 1'b1;
      default: pass = 1'b0;  // unassigned codes never execute
    endcase
  end
endmodule

// File: rtl/pxu_alu_core.sv
module pxu_alu_core
  import pxu_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input  logic [3:0]        op,
  input  logic [DATA_W-1:0] a,
  input  logic [DATA_W-1:0] b,
  input  logic              carry_in,
  output logic [DATA_W-1:0] result,
  output logic              carry_out,
  output logic              ovf
);
  localparam int MSB = DATA_W - 1;

  logic [DATA_W-1:0] x, y;
  logic              ci;
  logic [DATA_W:0]   sum;

  // one adder serves all arithmetic forms; subtraction is x + ~y + ci
  always_comb begin
    unique case (op)
      OP_ADD, OP_CMN: begin x = a; y = b;  ci = 1'b0;     end
      OP_ADC:         begin x = a; y = b;  ci = carry_in; end
      OP_SUB, OP_CMP: begin x = a; y = ~b; ci = 1'b1;     end
      OP_SBC:         begin x = a; y = ~b; ci = carry_in; end
      OP_RSB:         begin x = b; y = ~a; ci = 1'b1;     end
      OP_RSC:         begin x = b; y = ~a; ci = carry_in; end
      default:        begin x = a; y = b;  ci = 1'b0;     end
    endcase
  end

  assign sum       = {1'b0, x} + {1'b0, y} + {{DATA_W{1'b0}}, ci};
  assign carry_out = sum[DATA_W];
  assign ovf       = (x[MSB] == y[MSB]) && (sum[MSB] != x[MSB]);

  always_comb begin
    unique case (op)
      OP_AND, OP_TST: result = a & b;
      OP_EOR, OP_TEQ: result = a ^ b;
      OP_ORR:         result = a | b;
      OP_MOV:         result = b;
      OP_BIC:         result = a & ~b;
      OP_MVN:         result = ~b;
      default:        result = sum[MSB:0];
    endcase
  end
endmodule

// File: rtl/pxu_flag_next.sv
module pxu_flag_next
  import pxu_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input  logic [3:0]        flags_q,
  input  logic [DATA_W-1:0] result,
  input  logic              arith,
  input  logic              carry,
  input  logic              ovf,
  output logic [3:0]        flags_d
);
  always_comb begin
    flags_d       = flags_q;
    flags_d[FL_N] = result[DATA_W-1];
    flags_d[FL_Z] = (result == '0);
    if (arith) begin
      flags_d[FL_C] = carry;
      flags_d[FL_V] = ovf;
    end
  end
endmodule

// File: rtl/pred_exec_unit.sv
module pred_exec_unit
  import pxu_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  input  logic [3:0]        in_op,
  input  logic [3:0]        in_cond,
  input  logic              in_setf,
  input  logic [DATA_W-1:0] in_a,
  input  logic [DATA_W-1:0] in_b,
  output logic              out_valid,
  output logic              out_we,
  output logic [DATA_W-1:0] out_result,
  output logic [3:0]        out_flags
);
  logic              cond_pass;
  logic              cmp_op;
  logic [DATA_W-1:0] alu_res;
  logic              alu_c, alu_v;
  logic [3:0]        flags_d;

  logic              valid_q, we_q;
  logic [DATA_W-1:0] res_q;
  logic [3:0]        flags_q;

  logic              valid_d, we_d, res_en, flag_en;

  pxu_cond_check u_cond (
    .cond  (in_cond),
    .flags (flags_q),
    .pass  (cond_pass)
  );

  pxu_alu_core #(.DATA_W(DATA_W)) u_alu (
    .op        (in_op),
    .a         (in_a),
    .b         (in_b),
    .carry_in  (flags_q[FL_C]),
    .result    (alu_res),
    .carry_out (alu_c),
    .ovf       (alu_v)
  );

  pxu_flag_next #(.DATA_W(DATA_W)) u_fnext (
    .flags_q (flags_q),
    .result  (alu_res),
    .arith   (is_arith(in_op)),
    .carry   (alu_c),
    .ovf     (alu_v),
    .flags_d (flags_d)
  );

  assign cmp_op = is_compare(in_op);

  // next-state
  always_comb begin
    valid_d = in_valid;
    we_d    = in_valid & cond_pass & ~cmp_op;
    res_en  = we_d;
    flag_en = in_valid & cond_pass & (in_setf | cmp_op);
  end

  // registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      valid_q <= 1'b0;
      we_q    <= 1'b0;
      res_q   <= '0;
      flags_q <= 4'b0000;
    end else begin
      valid_q <= valid_d;
      we_q    <= we_d;
      if (res_en)  res_q   <= alu_res;
      if (flag_en) flags_q <= flags_d;
    end
  end

  assign out_valid  = valid_q;
  assign out_we     = we_q;
  assign out_result = res_q;
  assign out_flags  = flags_q;
endmodule

// File: rtl/pred_exec_unit_chk.sv
module pred_exec_unit_chk #(
  parameter int DATA_W = 32
) (
  input logic              clk,
  input logic              rst_n,
  input logic              in_valid,
  input logic [3:0]        in_op,
  input logic [3:0]        in_cond,
  input logic              in_setf,
  input logic [DATA_W-1:0] in_b,
  input logic              out_valid,
  input logic              out_we,
  input logic [DATA_W-1:0] out_result,
  input logic [3:0]        out_flags
);
  logic never_code, cmp_op, logic_op;
  assign never_code = in_cond[3] && (in_cond != 4'b1110);
  assign cmp_op     = (in_op[3:2] == 2'b10);
  assign logic_op   = (in_op inside {4'd0, 4'd1, 4'd8, 4'd9, 4'd12, 4'd13, 4'd14, 4'd15});

  AST_WE_HAS_VALID: assert property (@(posedge clk) disable iff (!rst_n)
    out_we |-> out_valid); // R2
  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> (!out_valid && $stable(out_flags))); // R2
  AST_NEVER_CODE_SKIPS: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && never_code) |=> (out_valid && !out_we && $stable(out_flags))); // R4
  AST_ALWAYS_WRITES: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_cond == 4'b1110 && !cmp_op) |=> out_we); // R3
  AST_CMP_NO_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && cmp_op) |=> !out_we); // R10
  AST_LOGIC_KEEPS_CV: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && logic_op) |=> (out_flags[1:0] == $past(out_flags[1:0]))); // R9
  AST_NOSETF_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && !in_setf && !cmp_op) |=> $stable(out_flags)); // R11
  AST_MOV_COPIES_B: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_cond == 4'b1110 && in_op == 4'd13) |=> (out_result == $past(in_b))); // R8
endmodule

bind pred_exec_unit pred_exec_unit_chk #(.DATA_W(DATA_W)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .in_valid   (in_valid),
  .in_op      (in_op),
  .in_cond    (in_cond),
  .in_setf    (in_setf),
  .in_b       (in_b),
  .out_valid  (out_valid),
  .out_we     (out_we),
  .out_result (out_result),
  .out_flags  (out_flags)
);

// File: tb/pred_exec_unit_bench.sv
`timescale 1ns/1ps
module pred_exec_unit_bench;
  import pxu_pkg::*;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        in_valid;
  logic [3:0]  in_op, in_cond;
  logic        in_setf;
  logic [31:0] in_a, in_b;
  logic        out_valid, out_we;
  logic [31:0] out_result;
  logic [3:0]  out_flags;

  int n_chk  = 0;
  int n_fail = 0;
  bit done   = 0;
  logic [3:0] mf;  // bench model of the flags {N,Z,C,V}

  always #10 clk = ~clk;  // 50 MHz

  pred_exec_unit u_pred_exec_unit (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_op(in_op), .in_cond(in_cond),
    .in_setf(in_setf), .in_a(in_a), .in_b(in_b), .out_valid(out_valid), .out_we(out_we),
    .out_result(out_result), .out_flags(out_flags)
  );

  task automatic chk(input string tag, input string what, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
    end
  endtask

  function automatic logic ref_pass(input logic [3:0] c, input logic [3:0] f);
    case (c)
      4'd0: return f[2] == 1'b1;
      4'd1: return f[2] == 1'b0;
      4'd2: return f[1] == 1'b1;
      4'd3: return f[1] == 1'b0;
      4'd4: return f[3] == 1'b1;
      4'd5: return f[3] == 1'b0;
      4'd6: return f[0] == 1'b1;
      4'd7: return f[0] == 1'b0;
      4'd14: return 1'b1;
      default: return 1'b0;
    endcase
  endfunction

  // integer model of add / subtract with carry and signed overflow
  task automatic ref_add(input logic [31:0] x, y, input logic ci,
                         output logic [31:0] r, output logic c, output logic v);
    longint unsigned u;
    longint s;
    u = longint'(x) + longint'(y) + longint'(ci);
    s = longint'($signed(x)) + longint'($signed(y)) + longint'(ci);
    r = u[31:0];
    c = (u >= 64'h1_0000_0000);
    v = (s > 64'sd2147483647) || (s < -64'sd2147483648);
  endtask

  task automatic ref_sub(input logic [31:0] x, y, input logic br,
                         output logic [31:0] r, output logic c, output logic v);
    longint s;
    s = longint'($signed(x)) - longint'($signed(y)) - longint'(br);
    r = x - y - {31'b0, br};
    c = (longint'(x) >= longint'(y) + longint'(br));
    v = (s > 64'sd2147483647) || (s < -64'sd2147483648);
  endtask

  // issue one instruction at a negedge, check its beat at the next negedge
  task automatic exec(input string tag, input logic [3:0] op, input logic [3:0] cond,
                      input logic setf, input logic [31:0] a, input logic [31:0] b);
    logic [31:0] r;
    logic c, v, ar, ps, cm, we;
    logic [3:0] nf;
    c = mf[1]; v = mf[0]; ar = 1'b1;
    case (op)
      4'd4, 4'd11: ref_add(a, b, 1'b0, r, c, v);
      4'd5:        ref_add(a, b, mf[1], r, c, v);
      4'd2, 4'd10: ref_sub(a, b, 1'b0, r, c, v);
      4'd6:        ref_sub(a, b, ~mf[1], r, c, v);
      4'd3:        ref_sub(b, a, 1'b0, r, c, v);
      4'd7:        ref_sub(b, a, ~mf[1], r, c, v);
      4'd0, 4'd8:  begin r = a & b;  ar = 1'b0; end
      4'd1, 4'd9:  begin r = a ^ b;  ar = 1'b0; end
      4'd12:       begin r = a | b;  ar = 1'b0; end
      4'd13:       begin r = b;      ar = 1'b0; end
      4'd14:       begin r = a & ~b; ar = 1'b0; end
      default:     begin r = ~b;     ar = 1'b0; end
    endcase
    ps = ref_pass(cond, mf);
    cm = (op >= 4'd8) && (op <= 4'd11);
    we = ps && !cm;
    nf = mf;
    if (ps && (setf || cm)) nf = {r[31], r == 32'd0, ar ? c : mf[1], ar ? v : mf[0]};
    in_valid = 1'b1; in_op = op; in_cond = cond; in_setf = setf; in_a = a; in_b = b;
    @(negedge clk);
    in_valid = 1'b0;
    chk(tag, "out_valid", 64'(out_valid), 64'd1);
    chk(tag, "out_we", 64'(out_we), 64'(we));
    if (we) chk(tag, "out_result", 64'(out_result), 64'(r));
    chk(tag, "out_flags", 64'(out_flags), 64'(nf));
    mf = nf;
  endtask

  task automatic t_reset();
    rst_n = 1'b0; in_valid = 1'b0; in_op = '0; in_cond = '0; in_setf = 1'b0; in_a = '0; in_b = '0;
    mf = 4'b0000;
    repeat (3) @(negedge clk);
    chk("R1", "out_valid in reset", 64'(out_valid), 64'd0);
    chk("R1", "out_we in reset", 64'(out_we), 64'd0);
    chk("R1", "flags in reset", 64'(out_flags), 64'd0);
    rst_n = 1'b1;
    @(negedge clk);
  endtask

  task automatic t_arith();
    exec("R5", OP_ADD, CC_AL, 1'b1, 32'd10, 32'd20);
    exec("R7", OP_ADD, CC_AL, 1'b1, 32'h7FFF_FFFF, 32'd1);
    chk("R7", "flags after signed overflow add", 64'(out_flags), 64'b1001);
    exec("R6", OP_ADD, CC_AL, 1'b1, 32'hFFFF_FFFF, 32'd1);
    chk("R6", "flags after carry-out add", 64'(out_flags), 64'b0110);
    exec("R5", OP_ADC, CC_AL, 1'b1, 32'd7, 32'd8);
    chk("R5", "adc uses carry", 64'(out_result), 64'd16);
    exec("R6", OP_SUB, CC_AL, 1'b1, 32'd3, 32'd5);
    chk("R6", "sub borrow result", 64'(out_result), 64'hFFFF_FFFE);
    chk("R6", "sub borrow flags", 64'(out_flags), 64'b1000);
    exec("R6", OP_SBC, CC_AL, 1'b1, 32'd10, 32'd4);
    chk("R6", "sbc with C clear", 64'(out_result), 64'd5);
    exec("R6", OP_RSB, CC_AL, 1'b1, 32'd3, 32'd5);
    chk("R6", "rsb result", 64'(out_result), 64'd2);
    chk("R6", "rsb no borrow flags", 64'(out_flags), 64'b0010);
    exec("R6", OP_RSC, CC_AL, 1'b1, 32'd5, 32'd5);
    exec("R7", OP_SUB, CC_AL, 1'b1, 32'h8000_0000, 32'd1);
    exec("R6", OP_SBC, CC_AL, 1'b1, 32'd0, 32'd0);
    exec("R6", OP_RSC, CC_AL, 1'b1, 32'h1234_5678, 32'h0000_0001);
  endtask

  task automatic t_logic();
    exec("R9", OP_ADD, CC_AL, 1'b1, 32'h7FFF_FFFF, 32'h8000_0001);  // C=1
    exec("R9", OP_SUB, CC_AL, 1'b1, 32'h8000_0000, 32'd1);          // C=1 V=1
    exec("R8", OP_AND, CC_AL, 1'b1, 32'hF0F0_F0F0, 32'h0F0F_0F0F);
    chk("R9", "and keeps C,V", 64'(out_flags), 64'b0111);
    exec("R8", OP_EOR, CC_AL, 1'b1, 32'hFFFF_0000, 32'h00FF_FF00);
    exec("R8", OP_ORR, CC_AL, 1'b1, 32'h8000_0000, 32'd1);
    exec("R8", OP_BIC, CC_AL, 1'b1, 32'hFFFF_FFFF, 32'h0000_FFFF);
    chk("R8", "bic result", 64'(out_result), 64'hFFFF_0000);
    exec("R8", OP_MOV, CC_AL, 1'b1, 32'hDEAD_BEEF, 32'h0);
    exec("R8", OP_MVN, CC_AL, 1'b1, 32'h0, 32'h0);
    chk("R8", "mvn result", 64'(out_result), 64'hFFFF_FFFF);
    chk("R9", "mvn flags keep C,V", 64'(out_flags), 64'b1011);
  endtask

  task automatic t_compare();
    exec("R10", OP_CMP, CC_AL, 1'b0, 32'd9, 32'd9);
    chk("R10", "cmp equal flags", 64'(out_flags), 64'b0110);
    exec("R10", OP_CMN, CC_AL, 1'b0, 32'h8000_0000, 32'h8000_0000);
    chk("R10", "cmn flags", 64'(out_flags), 64'b0111);
    exec("R10", OP_TST, CC_AL, 1'b0, 32'hAAAA_AAAA, 32'h5555_5555);
    exec("R10", OP_TEQ, CC_AL, 1'b0, 32'h8000_0000, 32'h0);
    exec("R10", OP_CMP, CC_NE, 1'b1, 32'd1, 32'd2);  // Z=0 after TEQ, passes
  endtask

  task automatic t_nosetf();
    exec("R11", OP_CMP, CC_AL, 1'b0, 32'd4, 32'd4);
    exec("R11", OP_SUB, CC_AL, 1'b0, 32'd1, 32'd2);
    chk("R11", "flags kept without setf", 64'(out_flags), 64'b0110);
    exec("R11", OP_MOV, CC_AL, 1'b0, 32'd0, 32'h8000_0000);
  endtask

  task automatic t_cond_sweep();
    for (int s = 0; s < 5; s++) begin
      case (s)
        0: exec("R3", OP_CMP, CC_AL, 1'b0, 32'd5, 32'd5);
        1: exec("R3", OP_CMP, CC_AL, 1'b0, 32'd3, 32'd5);
        2: exec("R3", OP_ADD, CC_AL, 1'b1, 32'h7FFF_FFFF, 32'd1);
        3: exec("R3", OP_CMN, CC_AL, 1'b0, 32'h8000_0000, 32'h8000_0000);
        default: exec("R3", OP_CMP, CC_AL, 1'b0, 32'd6, 32'd2);
      endcase
      for (int c = 0; c < 16; c++) begin
        if (ref_pass(4'(c), mf)) exec("R3", OP_ADD, 4'(c), 1'b0, 32'(c), 32'd100);
        else                     exec("R4", OP_ADD, 4'(c), 1'b1, 32'(c), 32'd100);
      end
    end
    // failing condition with setf must leave the flags as they were
    exec("R4", OP_CMP, CC_AL, 1'b0, 32'd1, 32'd1);  // Z=1
    exec("R4", OP_SUB, CC_NE, 1'b1, 32'd0, 32'd1);
    chk("R4", "failed cond keeps flags", 64'(out_flags), 64'b0110);
  endtask

  task automatic t_back_to_back();
    exec("R12", OP_CMP, CC_AL, 1'b0, 32'd9, 32'd9);
    exec("R12", OP_ADD, CC_EQ, 1'b0, 32'd1, 32'd2);
    chk("R12", "next-clock cond sees new Z", 64'(out_we), 64'd1);
    exec("R12", OP_CMP, CC_AL, 1'b0, 32'd1, 32'd9);
    exec("R12", OP_ADD, CC_EQ, 1'b0, 32'd1, 32'd2);
    chk("R12", "next-clock cond sees cleared Z", 64'(out_we), 64'd0);
  endtask

  task automatic t_idle();
    for (int i = 0; i < 3; i++) begin
      @(negedge clk);
      chk("R2", "no beat without in_valid", 64'(out_valid), 64'd0);
      chk("R2", "flags hold while idle", 64'(out_flags), 64'(mf));
    end
  endtask

  initial begin
    t_reset();
    t_arith();
    t_logic();
    t_compare();
    t_nosetf();
    t_cond_sweep();
    t_back_to_back();
    t_idle();
    if (!done) begin
      done = 1;
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      done = 1;
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end
endmodule